// File: doc/BRIEF.md
# ECC-Protected True Dual-Port RAM

This block is a single-clock memory with two fully independent ports, A and B. Either port can write or read on any cycle. Before a word is stored, an encoder on that port turns it into a single-error-correct, double-error-detect codeword. When a word is read, a decoder on that port checks the codeword, corrects it if needed, and reports what it found on two status flags.

Only the write data goes through the encoder. The address, the write strobe and the fault-injection control go through a matched register chain instead. That chain makes them reach the array in the same cycle as their encoded data. Port A has a fault-injection input that inverts bit 0 of the codeword as it is written. Bit 0 holds the overall parity, so setting it shows a single-bit correction in action without touching the data bits.

With default parameters the word is 32 bits wide and the codeword is 39 bits. Codeword bit 0 is the overall parity bit. Bit positions 1 to 38 hold an extended Hamming code: the parity bits sit at the power-of-two positions and the data bits fill the remaining positions in ascending order.

Top module: `ecc_tdp_ram`

## Requirements
- R1: A word written on either port reads back unchanged on both ports.
- R2: Read data and flags appear on the output in the third cycle after the read address is presented (ENC_LAT + 2 rising edges with the default ENC_LAT of 1). Until then the output keeps the previous result.
- R3: A write on port A made with `a_flip` high stores the codeword with bit 0 inverted. A later read of that word returns the original data with the corrected flag high.
- R4: Address, write strobe and flip control pass through a register chain whose length equals the encoder latency. As a result, a write is visible to a read presented one cycle after it.
- R5: Reading a clean codeword gives both flags low. Rewriting a word that was stored with a flipped bit, with `a_flip` low or through port B, makes its later reads clean.
- R6: The uncorrectable flag is never raised for a clean word or a single-bit error. The corrected flag and the uncorrectable flag are never high together.
- R7: A read presented in the same cycle as a write to the same address on the other port returns the previous contents. A read presented one cycle later returns the new word.
- R8: While `rst_n` is low, and on the first cycle after it rises, all read data and flag outputs are zero.
- R9: `a_flip` has no effect in a cycle where `a_we` is low: the stored word and its flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for encoders, array and decoders |
| rst_n | input | 1 | Synchronous active-low reset of pipeline and outputs |
| a_we | input | 1 | Port A write strobe |
| a_addr | input | ADDR_W | Port A word address (used for read and write) |
| a_wdata | input | DATA_W | Port A write data |
| a_flip | input | 1 | Port A fault injection: invert codeword bit 0 on this write |
| a_rdata | output | DATA_W | Port A corrected read data |
| a_fixed | output | 1 | Port A single-bit error corrected |
| a_fatal | output | 1 | Port A uncorrectable error detected |
| b_we | input | 1 | Port B write strobe |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B corrected read data |
| b_fixed | output | 1 | Port B single-bit error corrected |
| b_fatal | output | 1 | Port B uncorrectable error detected |

## Verification
The hardest case to reach from the ports is a collision between the two ports. A read on one port must meet a write on the other port at the array on the same edge, even though both requests travel through the bypass delay. The bench presents the port-A write and the port-B read of the same address in the same cycle. It then holds the read address and samples the output on the third and fourth cycles, which gives the old word and then the new one. Corrected reads are produced only through the flip input, on words that the bench first stores with the flip set and then rewrites clean.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

   // Number of Hamming check bits needed for k data bits
   function automatic int par_bits(input int k);
      int p;
      p = 0;
      while ((1 << p) < (k + p + 1)) p++;
      return p;
   endfunction

   typedef enum logic [1:0] {
      ST_CLEAN = 2'd0,
      ST_FIXED = 2'd1,
      ST_FATAL = 2'd2
   } ecc_status_e;

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc #(
   parameter int DATA_W = 32,
   parameter int LAT    = 1,
   localparam int P     = ecc_pkg::par_bits(DATA_W),
   localparam int CW_W  = DATA_W + P + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   output logic [CW_W-1:0]   cw_out
);

   function automatic logic [CW_W-1:0] encode(input logic [DATA_W-1:0] d);
      logic [CW_W-1:0] c;
      int j;
      c = '0;
      j = 0;
      for (int pos = 1; pos < CW_W; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            c[pos] = d[j];
            j++;
         end
      end
      for (int i = 0; i < P; i++) begin
         logic x;
         x = 1'b0;
         for (int pos = 1; pos < CW_W; pos++)
            if (((pos >> i) & 1) == 1) x = x ^ c[pos];
         c[1 << i] = x;
      end
      c[0] = ^c[CW_W-1:1];
      return c;
   endfunction

   logic [CW_W-1:0] stg [LAT];

   always_ff @(posedge clk) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= encode(din);
   end

   for (genvar s = 1; s < LAT; s++) begin : g_extra
      always_ff @(posedge clk) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign cw_out = stg[LAT-1];

   // Independent syndrome check on the encoder output
   function automatic logic [P-1:0] chk_syn(input logic [CW_W-1:0] c);
      logic [P-1:0] s;
      s = '0;
      for (int pos = 1; pos < CW_W; pos++)
         if (c[pos]) s = s ^ P'(pos);
      return s;
   endfunction

   a_r1_cw_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_syn(cw_out) == '0) && (^cw_out == 1'b0));

endmodule

// File: rtl/align_pipe.sv
module align_pipe #(
   parameter int W      = 8,
   parameter int STAGES = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES == 0) begin : g_wire
      assign q = d;
   end else begin : g_regs
      logic [W-1:0] r [STAGES];
      always_ff @(posedge clk) begin
         if (!rst_n) r[0] <= '0;
         else        r[0] <= d;
      end
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) r[s] <= '0;
            else        r[s] <= r[s-1];
         end
      end
      assign q = r[STAGES-1];

      if (STAGES == 1) begin : g_chk
         a_r4_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (q == $past(d)));
      end
   end

endmodule

// File: rtl/dp_array.sv
module dp_array #(
   parameter int W  = 39,
   parameter int AW = 5,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_a,
   input  logic [AW-1:0] addr_a,
   input  logic [W-1:0]  d_a,
   output logic [W-1:0]  q_a,
   input  logic          we_b,
   input  logic [AW-1:0] addr_b,
   input  logic [W-1:0]  d_b,
   output logic [W-1:0]  q_b
);

   logic [W-1:0] mem [DEPTH];

   // Read-first on both ports; equal-address double write is undefined
   always_ff @(posedge clk) begin
      q_a <= mem[addr_a];
      q_b <= mem[addr_b];
      if (we_a) mem[addr_a] <= d_a;
      if (we_b) mem[addr_b] <= d_b;
   end

   logic [W-1:0] cur_b;
   assign cur_b = mem[addr_b];

   a_r7_old_on_cross: assert property (@(posedge clk) disable iff (!rst_n)
      (we_a && !we_b && addr_a == addr_b) |=> (q_b == $past(cur_b)));

   a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we_a && !(we_b && addr_b == addr_a)) |=> (mem[$past(addr_a)] == $past(d_a)));

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec #(
   parameter int DATA_W = 32,
   localparam int P     = ecc_pkg::par_bits(DATA_W),
   localparam int CW_W  = DATA_W + P + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW_W-1:0]   cw_in,
   output logic [DATA_W-1:0] dout,
   output logic              fixed,
   output logic              fatal
);
   import ecc_pkg::*;

   logic [P-1:0]      syn;
   logic              odd;
   logic [CW_W-1:0]   fixed_cw;
   logic [DATA_W-1:0] data_c;
   ecc_status_e       st;

   always_comb begin
      syn = '0;
      for (int pos = 1; pos < CW_W; pos++)
         if (cw_in[pos]) syn = syn ^ P'(pos);
      odd      = ^cw_in;
      fixed_cw = cw_in;
      st       = ST_CLEAN;
      if (odd) begin
         if (int'(syn) < CW_W) begin
            fixed_cw[syn] = ~cw_in[syn];
            st = ST_FIXED;
         end else begin
            st = ST_FATAL;
         end
      end else if (syn != '0) begin
         st = ST_FATAL;
      end
   end

   always_comb begin
      int j;
      j = 0;
      data_c = '0;
      for (int pos = 1; pos < CW_W; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            data_c[j] = fixed_cw[pos];
            j++;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout  <= '0;
         fixed <= 1'b0;
         fatal <= 1'b0;
      end else begin
         dout  <= data_c;
         fixed <= (st == ST_FIXED);
         fatal <= (st == ST_FATAL);
      end
   end

   a_r6_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fixed, fatal}));

endmodule

// File: rtl/ecc_tdp_ram.sv
module ecc_tdp_ram #(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 5,
   parameter int ENC_LAT = 1,
   localparam int P      = ecc_pkg::par_bits(DATA_W),
   localparam int CW_W   = DATA_W + P + 1,
   localparam int CTL_W  = ADDR_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   input  logic              a_flip,
   output logic [DATA_W-1:0] a_rdata,
   output logic              a_fixed,
   output logic              a_fatal,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic              b_fixed,
   output logic              b_fatal
);

   if (DATA_W < 4 || DATA_W > 1024) begin : g_bad_w
      $error("DATA_W out of range");
   end
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_a
      $error("ADDR_W out of range");
   end
   if (ENC_LAT < 1 || ENC_LAT > 4) begin : g_bad_l
      $error("ENC_LAT out of range");
   end

   logic              we_i   [2];
   logic              flip_i [2];
   logic [ADDR_W-1:0] addr_i [2];
   logic [DATA_W-1:0] wd_i   [2];
   logic [CW_W-1:0]   cw_e   [2];
   logic [CW_W-1:0]   cw_w   [2];
   logic [CW_W-1:0]   cw_r   [2];
   logic [CTL_W-1:0]  ctl_d  [2];
   logic [DATA_W-1:0] rd_o   [2];
   logic              fx_o   [2];
   logic              ft_o   [2];

   assign we_i[0]   = a_we;
   assign addr_i[0] = a_addr;
   assign wd_i[0]   = a_wdata;
   assign flip_i[0] = a_flip;
   assign we_i[1]   = b_we;
   assign addr_i[1] = b_addr;
   assign wd_i[1]   = b_wdata;
   assign flip_i[1] = 1'b0;

   for (genvar p = 0; p < 2; p++) begin : g_port
      ecc_enc #(.DATA_W(DATA_W), .LAT(ENC_LAT)) u_enc (
         .clk(clk), .rst_n(rst_n), .din(wd_i[p]), .cw_out(cw_e[p]));

      align_pipe #(.W(CTL_W), .STAGES(ENC_LAT)) u_ctl (
         .clk(clk), .rst_n(rst_n),
         .d({we_i[p], flip_i[p], addr_i[p]}), .q(ctl_d[p]));

      // Fault injection: invert overall-parity bit on a flagged write
      assign cw_w[p] = cw_e[p] ^ {{(CW_W-1){1'b0}}, ctl_d[p][ADDR_W]};

      ecc_dec #(.DATA_W(DATA_W)) u_dec (
         .clk(clk), .rst_n(rst_n), .cw_in(cw_r[p]),
         .dout(rd_o[p]), .fixed(fx_o[p]), .fatal(ft_o[p]));
   end

   dp_array #(.W(CW_W), .AW(ADDR_W)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .we_a(ctl_d[0][CTL_W-1]), .addr_a(ctl_d[0][ADDR_W-1:0]),
      .d_a(cw_w[0]), .q_a(cw_r[0]),
      .we_b(ctl_d[1][CTL_W-1]), .addr_b(ctl_d[1][ADDR_W-1:0]),
      .d_b(cw_w[1]), .q_b(cw_r[1]));

   assign a_rdata = rd_o[0];
   assign a_fixed = fx_o[0];
   assign a_fatal = ft_o[0];
   assign b_rdata = rd_o[1];
   assign b_fixed = fx_o[1];
   assign b_fatal = ft_o[1];

   a_r8_quiet_after_reset: assert property (@(posedge clk)
      !$past(rst_n) |-> (a_rdata == '0 && b_rdata == '0 &&
                         !a_fixed && !a_fatal && !b_fixed && !b_fatal));

endmodule

// File: tb/ecc_tdp_ram_tb.sv
`timescale 1ns/1ps
module ecc_tdp_ram_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        a_we, a_flip, b_we;
   logic [4:0]  a_addr, b_addr;
   logic [31:0] a_wdata, b_wdata;
   logic [31:0] a_rdata, b_rdata;
   logic        a_fixed, a_fatal, b_fixed, b_fatal;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   ecc_tdp_ram dut_i (
      .clk(clk), .rst_n(rst_n),
      .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_flip(a_flip),
      .a_rdata(a_rdata), .a_fixed(a_fixed), .a_fatal(a_fatal),
      .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
      .b_rdata(b_rdata), .b_fixed(b_fixed), .b_fatal(b_fatal));

   // {addr[4:0], data[31:0], flip}
   localparam logic [37:0] VECS [8] = '{
      {5'd0,  32'h0000_0000, 1'b0},
      {5'd1,  32'hFFFF_FFFF, 1'b1},
      {5'd2,  32'hA5A5_5A5A, 1'b0},
      {5'd7,  32'h1234_5678, 1'b1},
      {5'd12, 32'h8000_0001, 1'b1},
      {5'd19, 32'hDEAD_BEEF, 1'b0},
      {5'd30, 32'h0F0F_F0F0, 1'b1},
      {5'd31, 32'h7FFF_FFFE, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_a(input logic [4:0] ad, input logic [31:0] d, input logic f);
      a_we = 1'b1; a_addr = ad; a_wdata = d; a_flip = f;
      @(negedge clk);
      a_we = 1'b0; a_flip = 1'b0;
   endtask

   task automatic wr_b(input logic [4:0] ad, input logic [31:0] d);
      b_we = 1'b1; b_addr = ad; b_wdata = d;
      @(negedge clk);
      b_we = 1'b0;
   endtask

   task automatic rd_both(input logic [4:0] ad);
      a_addr = ad; b_addr = ad;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0;
      a_we = 0; a_flip = 0; b_we = 0;
      a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
      repeat (4) @(negedge clk);
      // R8: outputs zero in reset
      chk("R8 a_rdata", a_rdata, 32'h0);
      chk("R8 b_rdata", b_rdata, 32'h0);
      chk("R8 flags", {28'h0, a_fixed, a_fatal, b_fixed, b_fatal}, 32'h0);
      rst_n = 1'b1;

      // R1 / R3: table walk, writes on port A with optional flip
      for (int i = 0; i < 8; i++) wr_a(VECS[i][37:33], VECS[i][32:1], VECS[i][0]);
      for (int i = 0; i < 8; i++) begin
         rd_both(VECS[i][37:33]);
         chk("R1 b_rdata", b_rdata, VECS[i][32:1]);
         chk("R1 a_rdata", a_rdata, VECS[i][32:1]);
         chk("R3 b_fixed", {31'h0, b_fixed}, {31'h0, VECS[i][0]});
         chk("R3 a_fixed", {31'h0, a_fixed}, {31'h0, VECS[i][0]});
         chk("R6 fatal", {30'h0, a_fatal, b_fatal}, 32'h0);
      end

      // R2: latency of three cycles on port B
      b_addr = VECS[2][37:33];
      repeat (3) @(negedge clk);
      b_addr = VECS[5][37:33];
      @(negedge clk);
      chk("R2 hold after 1", b_rdata, VECS[2][32:1]);
      @(negedge clk);
      chk("R2 hold after 2", b_rdata, VECS[2][32:1]);
      @(negedge clk);
      chk("R2 new after 3", b_rdata, VECS[5][32:1]);

      // R4: write then read presented the very next cycle
      wr_a(5'd9, 32'hC0DE_0009, 1'b0);
      b_addr = 5'd9;
      repeat (3) @(negedge clk);
      chk("R4 next-cycle read", b_rdata, 32'hC0DE_0009);

      // R5: rewrite flipped words clean, via port B and via port A
      wr_b(VECS[1][37:33], 32'h5555_AAAA);
      wr_a(VECS[3][37:33], 32'h3333_CCCC, 1'b0);
      rd_both(VECS[1][37:33]);
      chk("R5 data B-rewrite", a_rdata, 32'h5555_AAAA);
      chk("R5 clean B-rewrite", {30'h0, a_fixed, b_fixed}, 32'h0);
      rd_both(VECS[3][37:33]);
      chk("R5 data A-rewrite", b_rdata, 32'h3333_CCCC);
      chk("R5 clean A-rewrite", {30'h0, a_fixed, b_fixed}, 32'h0);

      // R9: flip without write has no effect
      a_we = 1'b0; a_flip = 1'b1; a_addr = VECS[2][37:33]; a_wdata = 32'hFFFF_0000;
      @(negedge clk);
      a_flip = 1'b0;
      rd_both(VECS[2][37:33]);
      chk("R9 data kept", b_rdata, VECS[2][32:1]);
      chk("R9 no fixed", {30'h0, a_fixed, b_fixed}, 32'h0);

      // R7: same-cycle cross-port read returns old, next cycle new
      a_we = 1'b1; a_addr = VECS[5][37:33]; a_wdata = 32'h0BAD_F00D;
      b_addr = VECS[5][37:33];
      @(negedge clk);
      a_we = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R7 old on collision", b_rdata, VECS[5][32:1]);
      @(negedge clk);
      chk("R7 new next cycle", b_rdata, 32'h0BAD_F00D);
      chk("R6 no fatal at end", {30'h0, a_fatal, b_fatal}, 32'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule